// File: doc/BRIEF.md
# I2C Target Transmitter with Clock Stretching

This block is an I2C target that watches the bus for its own 7-bit address and, when a master asks to read, returns bytes taken from a local transmit FIFO. SCL and SDA are handled as open-drain pins: each has a sampled input and an active-high drive-low enable. Both inputs pass through a two-flop synchronizer before the protocol logic sees them. SDA is changed only while the synchronized SCL is low.

Two transmit modes are offered. In just-in-time mode, software fills the FIFO after the address match. The block holds SCL low until software has cleared a transmit-lock flag and at least one byte is queued. In preload mode, bytes written before the match go out with no software step. Preload mode also works with clock stretching turned off: on underflow it then sends 0xFF and raises an underflow flag.

Whenever the block holds SCL low waiting for data, it keeps SCL low for a programmed number of further cycles once data is present. This gives the first bit setup time before the clock is released. A master NACK closes the transfer, and the FIFO level then shows how many loaded bytes were not sent. Leftover bytes are discarded before the next transmit.

Top module: `i2c_tgt_tx`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, every flag and `level` are 0. While `enable` is 0 the block does not acknowledge any address.
- R2: With `enable` at 1, the block drives ACK (SDA low in the 9th clock) when the first seven bits after a START equal `own_addr`, for either value of the R/W bit. Any other address gets no ACK and raises no flag.
- R3: On an address match, `ami_flag` and `lock_flag` rise together, and `rd_dir` takes the R/W bit (1 = master reads). The `clr_*` inputs clear their flag; a set in the same cycle wins.
- R4: With `jit_mode` at 1, on a read the block holds SCL low until `lock_flag` is 0 and the FIFO is not empty, whatever `stretch_en` is. FIFO writes are ignored while `lock_flag` is 1 in this mode.
- R5: When the block holds SCL low and data becomes available, it places the first bit on SDA and keeps SCL low for at least `hi_cnt` further clock cycles.
- R6: In a stretching mode (`jit_mode` or `stretch_en` at 1), if the FIFO is empty when the master ACKs a byte, SCL is held low until a byte is written.
- R7: Bytes go out MSB first, in write order. A NACK from the master after a byte sets `done_flag` and ends the transfer, and `level` then equals the loaded bytes not sent.
- R8: Leftover bytes are flushed automatically. In just-in-time mode this happens at the read address match. In preload mode it happens when `clr_done` is pulsed.
- R9: `thr_flag` is 1 exactly when `thr_ie` is 1 and `level` is at or below `thresh`.
- R10: In preload mode with `stretch_en` at 0, the block never drives SCL. A byte needed from an empty FIFO is sent as 0xFF and sets `unf_flag`.
- R11: The FIFO holds 8 bytes, and a write to a full FIFO is dropped. A write and a pop in the same cycle both take effect.
- R12: SDA drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Drive SCL low when 1 |
| sda_oe | output | 1 | Drive SDA low when 1 |
| enable | input | 1 | Block enable; address monitoring while 1 |
| jit_mode | input | 1 | 1 = just-in-time mode, 0 = preload mode |
| stretch_en | input | 1 | Allow clock stretching in preload mode |
| own_addr | input | 7 | Target address |
| hi_cnt | input | 8 | Extra SCL-low cycles after data is ready |
| thresh | input | 4 | FIFO threshold level |
| thr_ie | input | 1 | Threshold flag enable |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | FIFO write data |
| clr_ami | input | 1 | Clear address-match flag |
| clr_lock | input | 1 | Clear transmit-lock flag |
| clr_done | input | 1 | Clear done flag (flushes FIFO in preload mode) |
| clr_unf | input | 1 | Clear underflow flag |
| level | output | 4 | FIFO fill level |
| rd_dir | output | 1 | R/W bit of the last matched address |
| ami_flag | output | 1 | Address-match flag |
| lock_flag | output | 1 | Transmit-lock flag |
| done_flag | output | 1 | Transfer ended by NACK |
| unf_flag | output | 1 | Underflow occurred (preload, no stretch) |
| thr_flag | output | 1 | FIFO level at or below threshold |

## Verification
In just-in-time mode, a FIFO write can fall in the same cycle as the pop that loads the first byte of a held read. The bench provokes this by writing several bytes back to back right after clearing the lock while SCL is held. It then judges the result: the level must read one less than the number of bytes written, and the master must receive every byte in write order. A further concern is that a lock-flag clear and a write can land close together. The bench checks that a write made while the lock is still set leaves the level at zero.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_HOLD,
        ST_SETUP,
        ST_TX,
        ST_RACK
    } tgt_state_e;

    localparam logic [7:0] UNDERFLOW_BYTE = 8'hFF;

endpackage

// File: rtl/i2c_sync2.sv
module i2c_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '1;
            s2_q <= '1;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign dout = s2_q;

endmodule

// File: rtl/i2c_tx_fifo.sv
module i2c_tx_fifo #(
    parameter  int DEPTH = 8,
    parameter  int W     = 8,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty
);

    typedef struct packed {
        logic [PW-1:0] rp;
        logic [PW-1:0] wp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t   q, d;
    logic [W-1:0] mem [DEPTH];
    logic full, push_ok, pop_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (push_ok) d.wp = bump(q.wp);
            if (pop_ok)  d.rp = bump(q.rp);
            d.cnt = q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[q.wp] <= din;
    end

    assign head  = mem[q.rp];
    assign count = q.cnt;

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/i2c_tgt_tx.sv
module i2c_tgt_tx
    import i2c_tgt_pkg::*;
#(
    parameter  int DEPTH = 8,
    parameter  int HCW   = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scl_i,
    input  logic           sda_i,
    output logic           scl_oe,
    output logic           sda_oe,
    input  logic           enable,
    input  logic           jit_mode,
    input  logic           stretch_en,
    input  logic [6:0]     own_addr,
    input  logic [HCW-1:0] hi_cnt,
    input  logic [CW-1:0]  thresh,
    input  logic           thr_ie,
    input  logic           wr_en,
    input  logic [7:0]     wr_data,
    input  logic           clr_ami,
    input  logic           clr_lock,
    input  logic           clr_done,
    input  logic           clr_unf,
    output logic [CW-1:0]  level,
    output logic           rd_dir,
    output logic           ami_flag,
    output logic           lock_flag,
    output logic           done_flag,
    output logic           unf_flag,
    output logic           thr_flag
);

    typedef struct packed {
        tgt_state_e     st;
        logic [2:0]     bits;
        logic [7:0]     shreg;
        logic [HCW-1:0] cnt;
        logic           scl_p;
        logic           sda_p;
        logic           scl_oe;
        logic           sda_oe;
        logic           acked;
        logic           rd;
        logic           ami;
        logic           lock;
        logic           done;
        logic           unf;
    } tgt_st_t;

    tgt_st_t q, d;

    logic       scl_s, sda_s;
    logic       rise, fall, start_c, stop_c;
    logic       stretch_on, wr_ok, pop_req, flush_req, begin_byte;
    logic [7:0] head;
    logic       empty;

    i2c_sync2 #(.W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout ({scl_s, sda_s})
    );

    i2c_tx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (wr_ok),
        .din  (wr_data),
        .pop  (pop_req),
        .flush(flush_req),
        .head (head),
        .count(level),
        .empty(empty)
    );

    assign rise       = scl_s && !q.scl_p;
    assign fall       = !scl_s && q.scl_p;
    assign start_c    = q.sda_p && !sda_s && scl_s && q.scl_p;
    assign stop_c     = !q.sda_p && sda_s && scl_s && q.scl_p;
    assign stretch_on = jit_mode || stretch_en;
    assign wr_ok      = wr_en && !(jit_mode && q.lock);

    always_comb begin
        d          = q;
        pop_req    = 1'b0;
        flush_req  = 1'b0;
        begin_byte = 1'b0;
        d.scl_p    = scl_s;
        d.sda_p    = sda_s;

        if (clr_ami)  d.ami  = 1'b0;
        if (clr_lock) d.lock = 1'b0;
        if (clr_unf)  d.unf  = 1'b0;
        if (clr_done) begin
            d.done = 1'b0;
            if (!jit_mode) flush_req = 1'b1;
        end

        unique case (q.st)
            ST_ADDR: begin
                if (rise && q.cnt != HCW'(8)) begin
                    d.shreg = {q.shreg[6:0], sda_s};
                    d.cnt   = q.cnt + 1'b1;
                end else if (fall && q.cnt == HCW'(8)) begin
                    if (q.shreg[7:1] == own_addr) begin
                        d.sda_oe = 1'b1;
                        d.ami    = 1'b1;
                        d.lock   = 1'b1;
                        d.rd     = q.shreg[0];
                        d.st     = ST_AACK;
                        if (q.shreg[0] && jit_mode) flush_req = 1'b1;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_AACK: begin
                if (fall) begin
                    d.sda_oe = 1'b0;
                    if (q.rd) begin_byte = 1'b1;
                    else      d.st       = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if ((!jit_mode || !q.lock) && !empty) begin
                    pop_req  = 1'b1;
                    d.shreg  = head;
                    d.sda_oe = !head[7];
                    d.cnt    = hi_cnt;
                    d.st     = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (q.cnt == '0) begin
                    d.scl_oe = 1'b0;
                    d.bits   = '0;
                    d.st     = ST_TX;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_TX: begin
                if (fall) begin
                    if (q.bits == 3'd7) begin
                        d.sda_oe = 1'b0;
                        d.acked  = 1'b0;
                        d.st     = ST_RACK;
                    end else begin
                        d.shreg  = {q.shreg[6:0], 1'b0};
                        d.sda_oe = !q.shreg[6];
                        d.bits   = q.bits + 1'b1;
                    end
                end
            end
            ST_RACK: begin
                if (rise) begin
                    if (sda_s) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.acked = 1'b1;
                    end
                end else if (fall && q.acked) begin
                    begin_byte = 1'b1;
                end
            end
            default: ;
        endcase

        if (begin_byte) begin
            if (stretch_on) begin
                d.scl_oe = 1'b1;
                d.st     = ST_HOLD;
            end else begin
                d.st   = ST_TX;
                d.bits = '0;
                if (!empty) begin
                    pop_req  = 1'b1;
                    d.shreg  = head;
                    d.sda_oe = !head[7];
                end else begin
                    d.shreg  = UNDERFLOW_BYTE;
                    d.sda_oe = 1'b0;
                    d.unf    = 1'b1;
                end
            end
        end

        if (start_c) begin
            d.st     = ST_ADDR;
            d.cnt    = '0;
            d.sda_oe = 1'b0;
            d.scl_oe = 1'b0;
        end else if (stop_c) begin
            d.st     = ST_IDLE;
            d.sda_oe = 1'b0;
            d.scl_oe = 1'b0;
        end

        if (!enable) begin
            d.st     = ST_IDLE;
            d.sda_oe = 1'b0;
            d.scl_oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign scl_oe    = q.scl_oe;
    assign sda_oe    = q.sda_oe;
    assign rd_dir    = q.rd;
    assign ami_flag  = q.ami;
    assign lock_flag = q.lock;
    assign done_flag = q.done;
    assign unf_flag  = q.unf;
    assign thr_flag  = thr_ie && (level <= thresh);

    // R3
    match_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ami_flag) |-> lock_flag);

    // R4
    lock_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jit_mode && lock_flag && wr_en && !pop_req && !flush_req) |=> $stable(level));

    // R10
    no_scl_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (begin_byte && !stretch_on) |=> !scl_oe);

    // R12
    sda_low_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && (sda_oe != $past(sda_oe))) |-> !$past(scl_s));

endmodule

// File: tb/i2c_tgt_tx_tb.sv
module i2c_tgt_tx_tb;

    localparam int         T    = 16;
    localparam logic [6:0] ADDR = 7'h2C;
    // {3'b0, jit, 3'b0, stretch, n_load, n_read}
    localparam logic [15:0] VEC [6] = '{16'h0132, 16'h0044, 16'h0023,
                                        16'h1033, 16'h1152, 16'h0188};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_line, sda_line;
    logic scl_oe, sda_oe;
    logic enable = 1'b0, jit_mode = 1'b0, stretch_en = 1'b1;
    logic [7:0] hi_cnt = 8'd10;
    logic [3:0] thresh = 4'd0;
    logic thr_ie = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic clr_ami = 1'b0, clr_lock = 1'b0, clr_done = 1'b0, clr_unf = 1'b0;
    logic [3:0] level;
    logic rd_dir, ami_flag, lock_flag, done_flag, unf_flag, thr_flag;

    int tests = 0, fails = 0, cyc = 0;
    int r12_viol = 0, r10_viol = 0;
    logic mon_nostr = 1'b0;
    logic sda_oe_prev = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;

    i2c_tgt_tx u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .enable(enable), .jit_mode(jit_mode),
        .stretch_en(stretch_en), .own_addr(ADDR), .hi_cnt(hi_cnt), .thresh(thresh),
        .thr_ie(thr_ie), .wr_en(wr_en), .wr_data(wr_data), .clr_ami(clr_ami),
        .clr_lock(clr_lock), .clr_done(clr_done), .clr_unf(clr_unf), .level(level),
        .rd_dir(rd_dir), .ami_flag(ami_flag), .lock_flag(lock_flag),
        .done_flag(done_flag), .unf_flag(unf_flag), .thr_flag(thr_flag)
    );

    always @(negedge clk) begin
        if (rst_n && sda_oe != sda_oe_prev && scl_line) r12_viol++;
        if (mon_nostr && scl_oe) r10_viol++;
        sda_oe_prev <= sda_oe;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k, input int i);
        return 8'(8'h5A + k * 37 + i * 11);
    endfunction

    task automatic m_start();
        @(negedge clk); m_sda = 1'b1; m_scl = 1'b1;
        repeat (T) @(negedge clk); m_sda = 1'b0;
        repeat (T) @(negedge clk); m_scl = 1'b0;
    endtask

    task automatic m_stop();
        repeat (4) @(negedge clk); m_sda = 1'b0;
        repeat (T) @(negedge clk); m_scl = 1'b1;
        repeat (T) @(negedge clk); m_sda = 1'b1;
        repeat (T) @(negedge clk);
    endtask

    task automatic m_bit(input logic b, output logic r);
        repeat (4) @(negedge clk); m_sda = b;
        repeat (T) @(negedge clk); m_scl = 1'b1;
        wait (scl_line == 1'b1);
        repeat (T) @(negedge clk); r = sda_line;
        m_scl = 1'b0;
    endtask

    task automatic m_byte_wr(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) m_bit(v[i], a);
        m_bit(1'b1, a);
        ack = !a;
    endtask

    task automatic m_byte_rd(input logic last, output logic [7:0] v);
        logic r;
        for (int i = 0; i < 8; i++) begin
            m_bit(1'b1, r);
            v = {v[6:0], r};
        end
        m_bit(last, r);
    endtask

    task automatic push_n(input int n, input int k, input logic [7:0] fixed, input logic use_fixed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); wr_en = 1'b1; wr_data = use_fixed ? fixed : pat(k, i);
        end
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic clr_all();
        @(negedge clk); clr_ami = 1; clr_lock = 1; clr_done = 1; clr_unf = 1;
        @(negedge clk); clr_ami = 0; clr_lock = 0; clr_done = 0; clr_unf = 0;
    endtask

    task automatic clr_lock_p();
        @(negedge clk); clr_lock = 1'b1;
        @(negedge clk); clr_lock = 1'b0;
    endtask

    task automatic cfg(input logic jv, input logic sv);
        @(negedge clk); enable = 1'b0; jit_mode = jv; stretch_en = sv;
        @(negedge clk); enable = 1'b1;
    endtask

    task automatic master_read(input int k, input int nr, input int nl);
        logic [7:0] v;
        for (int i = 0; i < nr; i++) begin
            m_byte_rd(i == nr - 1, v);
            if (i < nl) chk("R7", "read byte", v, pat(k, i));
            else        chk("R10", "underflow byte", v, 8'hFF);
        end
    endtask

    initial begin
        logic ack;
        logic [7:0] v;
        int t0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset drives", {scl_oe, sda_oe}, 2'b00);
        chk("R1", "reset flags", {ami_flag, lock_flag, done_flag, unf_flag}, 4'h0);
        chk("R1", "reset level", level, 0);

        // R1 disabled: no ACK
        m_start(); m_byte_wr({ADDR, 1'b1}, ack); m_stop();
        chk("R1", "ack while disabled", ack, 1'b0);
        chk("R1", "ami while disabled", ami_flag, 1'b0);

        // R2 mismatch
        cfg(1'b0, 1'b1);
        m_start(); m_byte_wr({7'h2D, 1'b1}, ack); m_stop();
        chk("R2", "ack other address", ack, 1'b0);
        chk("R2", "ami other address", ami_flag, 1'b0);

        // R2/R3 write direction
        m_start(); m_byte_wr({ADDR, 1'b0}, ack);
        chk("R2", "ack write dir", ack, 1'b1);
        chk("R3", "flags write dir {ami,lock,rd}", {ami_flag, lock_flag, rd_dir}, 3'b110);
        m_stop();

        // table walk
        for (int k = 0; k < 6; k++) begin
            logic jv, sv;
            int nl, nr, lexp;
            jv = VEC[k][12]; sv = VEC[k][8]; nl = int'(VEC[k][7:4]); nr = int'(VEC[k][3:0]);
            lexp = (nl > nr) ? nl - nr : 0;
            cfg(jv, sv);
            clr_all();
            if (jv) push_n(2, k, 8'hEE, 1'b1);
            else    push_n(nl, k, 8'h00, 1'b0);
            mon_nostr = !jv && !sv;
            r10_viol = 0;
            m_start();
            m_byte_wr({ADDR, 1'b1}, ack);
            chk("R2", "ack read", ack, 1'b1);
            chk("R3", "flags read {ami,lock,rd}", {ami_flag, lock_flag, rd_dir}, 3'b111);
            if (jv) begin
                fork
                    master_read(k, nr, nl);
                    begin
                        repeat (3 * T) @(negedge clk);
                        chk("R4", "scl held after match", scl_line, 1'b0);
                        chk("R8", "flush at read match", level, 0);
                        push_n(1, k, 8'h77, 1'b1);
                        chk("R4", "write ignored while locked", level, 0);
                        clr_lock_p();
                        push_n(nl, k, 8'h00, 1'b0);
                        chk("R11", "write with coincident pop", level, nl - 1);
                    end
                join
            end else begin
                master_read(k, nr, nl);
            end
            repeat (8) @(negedge clk);
            chk("R7", "done after nack", done_flag, 1'b1);
            chk("R7", "unsent level", level, lexp);
            chk("R10", "underflow flag", unf_flag, (!jv && !sv && nr > nl));
            if (!jv && !sv) chk("R10", "scl never driven", r10_viol, 0);
            m_stop();
            mon_nostr = 1'b0;
            if (!jv) begin
                clr_all();
                chk("R8", "flush on done clear", level, 0);
            end
        end

        // R5 setup count
        @(negedge clk); enable = 1'b0; jit_mode = 1'b1; hi_cnt = 8'd40;
        @(negedge clk); enable = 1'b1;
        clr_all();
        m_start(); m_byte_wr({ADDR, 1'b1}, ack);
        t0 = 0;
        fork
            begin
                m_byte_rd(1'b1, v);
                chk("R5", "byte after setup", v, pat(7, 0));
            end
            begin
                repeat (3 * T) @(negedge clk);
                clr_lock_p();
                @(negedge clk); wr_en = 1'b1; wr_data = pat(7, 0); t0 = cyc;
                @(negedge clk); wr_en = 1'b0;
                wait (scl_line == 1'b1);
                chk("R5", "hold >= hi_cnt", (cyc - t0 >= 40) && (cyc - t0 <= 50), 1'b1);
            end
        join
        m_stop();
        @(negedge clk); enable = 1'b0; hi_cnt = 8'd10;

        // R6 mid-transfer stretch
        cfg(1'b0, 1'b1);
        clr_all();
        push_n(1, 9, 8'h00, 1'b0);
        m_start(); m_byte_wr({ADDR, 1'b1}, ack);
        fork
            begin
                m_byte_rd(1'b0, v);
                chk("R6", "first byte", v, pat(9, 0));
                m_byte_rd(1'b1, v);
                chk("R6", "byte after refill", v, pat(9, 1));
            end
            begin
                repeat (700) @(negedge clk);
                chk("R6", "scl held on empty", scl_line, 1'b0);
                chk("R6", "not done while held", done_flag, 1'b0);
                @(negedge clk); wr_en = 1'b1; wr_data = pat(9, 1);
                @(negedge clk); wr_en = 1'b0;
            end
        join
        m_stop();

        // R9 threshold
        clr_all();
        @(negedge clk); thresh = 4'd2; thr_ie = 1'b1;
        @(negedge clk);
        chk("R9", "thr at level 0", thr_flag, 1'b1);
        push_n(2, 0, 8'h11, 1'b1);
        chk("R9", "thr at level == thresh", thr_flag, 1'b1);
        push_n(1, 0, 8'h12, 1'b1);
        chk("R9", "thr above thresh", thr_flag, 1'b0);
        clr_all();
        @(negedge clk); thr_ie = 1'b0;
        @(negedge clk);
        chk("R9", "thr disabled", thr_flag, 1'b0);

        // R11 full FIFO
        push_n(10, 3, 8'h00, 1'b0);
        chk("R11", "level capped at depth", level, 8);
        clr_all();

        chk("R12", "sda changed while scl high", r12_viol, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog: actual=hung expected=complete");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule